// File: doc/BRIEF.md
# Run-time reconfigurable precision floating-point multiplier

This block multiplies two floating-point operands. Each is a 64-bit double-precision word with a 3-bit precision selector placed above it. The selector chooses one of six mantissa widths. Both operands are cut to that width before the multiply, so a narrower setting gives a cheaper approximate product. The result word keeps the same layout and repeats the selector.

The significand product comes from a two-stage pipelined Karatsuba split. Its three sub-products are each formed by column-wise (vertical and crosswise) summation of bit products. Sign, exponent, zero, overflow and underflow handling run alongside the mantissa pipeline. A pair of operands whose selectors disagree, or that carry an unassigned selector, gives an error flag in place of a result. A new pair can be issued on every clock.

Top module: `fpm_multiplier`

## Requirements
- R1: Operand and result layout: bits 66:64 selector, bit 63 sign, bits 62:52 biased exponent, bits 51:0 fraction. A valid result carries the operand selector in bits 66:64.
- R2: Selector codes 0,1,2,3,4,5 keep the top 52,42,32,23,16,10 fraction bits of both operands. The remaining low bits are cleared before multiplying.
- R3: If the two selectors differ, or the selector is 6 or 7, the result slot shows out_err=1, out_valid=0 and out_word=0.
- R4: The result sign is the XOR of the two operand signs.
- R5: The result exponent is ea+eb-1023, plus 1 when the product of the two significands (hidden bit included) is 2 or more.
- R6: The result fraction is the normalized significand product (shifted right one place when it is 2 or more), truncated, with the fraction bits below the selected precision cleared.
- R7: If either operand has a zero exponent field, the result is a zero with the XOR sign (exponent 0, fraction 0).
- R8: If the final exponent is 2047 or more, the result is infinity: exponent 2047, fraction 0, XOR sign.
- R9: If the final exponent is 0 or less, the result is a zero with the XOR sign.
- R10: Each accepted pair gives exactly one out_valid or out_err pulse 4 cycles later. Pairs may be issued back to back. Cycles with in_valid low give no output.
- R11: While rst is high, out_valid, out_err and out_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 67 | First operand: selector and double word |
| op_b | input | 67 | Second operand: selector and double word |
| out_valid | output | 1 | Result word is valid |
| out_err | output | 1 | Selector error for this slot |
| out_word | output | 67 | Result: selector and double word |

## Verification
Every result, whether a product, a special value or an error, is due on the fourth rising edge after the edge that accepts its operands. The driver stamps each expected item with that due cycle. The monitor compares only at the falling edge of the due cycle, and any output seen without a due item is a mismatch. After the pipeline drains, a stretch of idle cycles with changing operand data confirms that no output appears.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int MODE_W   = 3;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int WORD_W   = MODE_W + 1 + EXP_W + FRAC_W;
    localparam int ESUM_W   = EXP_W + 2;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int NUM_MODES = 6;

    typedef enum logic [MODE_W-1:0] {
        PREC_52 = 3'd0,
        PREC_42 = 3'd1,
        PREC_32 = 3'd2,
        PREC_23 = 3'd3,
        PREC_16 = 3'd4,
        PREC_10 = 3'd5
    } prec_e;

    typedef struct packed {
        logic                     valid;
        logic                     err;
        logic [MODE_W-1:0]        mode;
        logic                     sign;
        logic                     zero;
        logic signed [ESUM_W-1:0] exp_sum;
    } side_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return int'(m) < NUM_MODES;
    endfunction

    function automatic int unsigned keep_bits(input logic [MODE_W-1:0] m);
        case (m)
            PREC_52: return 52;
            PREC_42: return 42;
            PREC_32: return 32;
            PREC_23: return 23;
            PREC_16: return 16;
            PREC_10: return 10;
            default: return FRAC_W;
        endcase
    endfunction

    function automatic logic [FRAC_W-1:0] frac_mask(input logic [MODE_W-1:0] m);
        return {FRAC_W{1'b1}} << (FRAC_W - keep_bits(m));
    endfunction

endpackage

// File: rtl/fpm_prep.sv
module fpm_prep
    import fpm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    op_a,
    input  logic [WORD_W-1:0]    op_b,
    output side_t                side_q,
    output logic [SIG_W-1:0]     sig_a_q,
    output logic [SIG_W-1:0]     sig_b_q
);

    logic [MODE_W-1:0] mode_a, mode_b;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [FRAC_W-1:0] mask;
    logic              bad_mode;
    side_t             side_d;

    assign mode_a = op_a[WORD_W-1 -: MODE_W];
    assign mode_b = op_b[WORD_W-1 -: MODE_W];
    assign exp_a  = op_a[FRAC_W +: EXP_W];
    assign exp_b  = op_b[FRAC_W +: EXP_W];
    assign mask   = frac_mask(mode_a);

    always_comb begin
        bad_mode       = (mode_a != mode_b) || !mode_legal(mode_a);
        side_d.err     = in_valid && bad_mode;
        side_d.valid   = in_valid && !bad_mode;
        side_d.mode    = mode_a;
        side_d.sign    = op_a[FRAC_W+EXP_W] ^ op_b[FRAC_W+EXP_W];
        side_d.zero    = (exp_a == '0) || (exp_b == '0);
        side_d.exp_sum = ESUM_W'($signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - EXP_BIAS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q  <= '0;
            sig_a_q <= '0;
            sig_b_q <= '0;
        end else begin
            side_q  <= side_d;
            sig_a_q <= {|exp_a, op_a[FRAC_W-1:0] & mask};
            sig_b_q <= {|exp_b, op_b[FRAC_W-1:0] & mask};
        end
    end

    AST_PREP_TRUNC: assert property (@(posedge clk) disable iff (rst)
        side_q.valid |-> (((sig_a_q[FRAC_W-1:0] | sig_b_q[FRAC_W-1:0]) & ~frac_mask(side_q.mode)) == '0)); // R2

endmodule

// File: rtl/fpm_urdhva_mul.sv
module fpm_urdhva_mul #(
    parameter int W = 27
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int PW = 2 * W;
    localparam int CW = $clog2(W + 1);

    always_comb begin
        p = '0;
        for (int k = 0; k < PW - 1; k++) begin
            logic [CW-1:0] col;
            col = '0;
            for (int i = 0; i < W; i++) begin
                if ((k - i) >= 0 && (k - i) < W) begin
                    col = col + CW'(a[i] & b[k-i]);
                end
            end
            p = p + (PW'(col) << k);
        end
    end

endmodule

// File: rtl/fpm_karatsuba_mul.sv
module fpm_karatsuba_mul #(
    parameter int W      = 53,
    parameter int KEEP_W = 54
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [KEEP_W-1:0] p_q
);

    localparam int LO_W   = (W + 1) / 2;
    localparam int HI_W   = W - LO_W;
    localparam int SUM_W  = LO_W + 1;
    localparam int PW     = 2 * W;
    localparam int MID_W  = 2 * SUM_W;
    localparam int DROP_W = PW - KEEP_W;

    logic [SUM_W-1:0]    sum_a, sum_b;
    logic [2*LO_W-1:0]   pl, pl_q;
    logic [2*HI_W-1:0]   ph, ph_q;
    logic [MID_W-1:0]    pm, pm_q;
    logic [MID_W-1:0]    mid;

    assign sum_a = SUM_W'(a[LO_W-1:0]) + SUM_W'(a[W-1:LO_W]);
    assign sum_b = SUM_W'(b[LO_W-1:0]) + SUM_W'(b[W-1:LO_W]);

    fpm_urdhva_mul #(.W(LO_W))  u_lo  (.a(a[LO_W-1:0]), .b(b[LO_W-1:0]), .p(pl));
    fpm_urdhva_mul #(.W(HI_W))  u_hi  (.a(a[W-1:LO_W]), .b(b[W-1:LO_W]), .p(ph));
    fpm_urdhva_mul #(.W(SUM_W)) u_mid (.a(sum_a),       .b(sum_b),       .p(pm));

    always_ff @(posedge clk) begin
        if (rst) begin
            pl_q <= '0;
            ph_q <= '0;
            pm_q <= '0;
        end else begin
            pl_q <= pl;
            ph_q <= ph;
            pm_q <= pm;
        end
    end

    assign mid = pm_q - MID_W'(pl_q) - MID_W'(ph_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else begin
            p_q <= KEEP_W'(((PW'(ph_q) << (2 * LO_W)) + (PW'(mid) << LO_W) + PW'(pl_q)) >> DROP_W);
        end
    end

    AST_KARA_MID: assert property (@(posedge clk) disable iff (rst)
        pm_q >= (MID_W'(pl_q) + MID_W'(ph_q))); // R6

endmodule

// File: rtl/fpm_post.sv
module fpm_post
    import fpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  side_t               side,
    input  logic [SIG_W:0]      prod_hi,
    output logic                out_valid,
    output logic                out_err,
    output logic [WORD_W-1:0]   out_word
);

    logic                     ovf_bit;
    logic [FRAC_W-1:0]        mant;
    logic signed [ESUM_W-1:0] exp_fin;
    logic [WORD_W-1:0]        word_d;

    assign ovf_bit = prod_hi[SIG_W];

    always_comb begin
        mant    = ovf_bit ? prod_hi[SIG_W-1:1] : prod_hi[FRAC_W-1:0];
        mant    = mant & frac_mask(side.mode);
        exp_fin = side.exp_sum + $signed({{(ESUM_W-1){1'b0}}, ovf_bit});
        if (!side.valid) begin
            word_d = '0;
        end else if (side.zero || exp_fin <= 0) begin
            word_d = {side.mode, side.sign, {(EXP_W+FRAC_W){1'b0}}};
        end else if (exp_fin >= EXP_MAX) begin
            word_d = {side.mode, side.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word_d = {side.mode, side.sign, exp_fin[EXP_W-1:0], mant};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= side.valid;
            out_err   <= side.err;
            out_word  <= word_d;
        end
    end

    AST_INF_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[FRAC_W +: EXP_W] == {EXP_W{1'b1}}) |-> out_word[FRAC_W-1:0] == '0); // R8

    AST_ERR_BLANK: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_word == '0); // R3

endmodule

// File: rtl/fpm_multiplier.sv
module fpm_multiplier
    import fpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [66:0]         op_a,
    input  logic [66:0]         op_b,
    output logic                out_valid,
    output logic                out_err,
    output logic [66:0]         out_word
);

    localparam int MUL_STAGES = 2;
    localparam int LAT        = MUL_STAGES + 2;

    side_t            side_pipe [MUL_STAGES+1];
    logic [SIG_W-1:0] sig_a, sig_b;
    logic [SIG_W:0]   prod_hi;

    fpm_prep u_prep (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .side_q   (side_pipe[0]),
        .sig_a_q  (sig_a),
        .sig_b_q  (sig_b)
    );

    fpm_karatsuba_mul #(.W(SIG_W), .KEEP_W(SIG_W + 1)) u_mul (
        .clk (clk),
        .rst (rst),
        .a   (sig_a),
        .b   (sig_b),
        .p_q (prod_hi)
    );

    for (genvar s = 0; s < MUL_STAGES; s++) begin : g_side
        always_ff @(posedge clk) begin
            if (rst) side_pipe[s+1] <= '0;
            else     side_pipe[s+1] <= side_pipe[s];
        end
    end

    fpm_post u_post (
        .clk       (clk),
        .rst       (rst),
        .side      (side_pipe[MUL_STAGES]),
        .prod_hi   (prod_hi),
        .out_valid (out_valid),
        .out_err   (out_err),
        .out_word  (out_word)
    );

    logic [2:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                   warm_q <= '0;
        else if (warm_q < 3'(LAT)) warm_q <= warm_q + 3'd1;
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err)); // R3

    AST_MODE_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> mode_legal(out_word[66:64])); // R1

    AST_TRUNC_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[FRAC_W-1:0] & ~frac_mask(out_word[66:64])) == '0); // R6

    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[62:52] == '0) |-> out_word[FRAC_W-1:0] == '0); // R7

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 3'(LAT)) |-> ((out_valid || out_err) == $past(in_valid, 4))); // R10

endmodule

// File: tb/fpm_multiplier_tb.sv
module fpm_multiplier_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [66:0] op_a, op_b;
    logic        out_valid, out_err;
    logic [66:0] out_word;

    always #2 clk = ~clk;

    fpm_multiplier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_err(out_err), .out_word(out_word)
    );

    typedef struct {
        int          due;
        bit          v;
        bit          e;
        logic [66:0] w;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic [63:0] rs = 64'h9E3779B97F4A7C15;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [66:0] mk(input int m, input bit s, input int e, input logic [51:0] f);
        return {3'(m), s, 11'(e), f};
    endfunction

    function automatic logic [66:0] ref_word(input logic [66:0] a, input logic [66:0] b, output bit err);
        logic [2:0]   m;
        int           k;
        int           e;
        logic [51:0]  mask;
        logic [52:0]  sa, sb;
        logic [105:0] p;
        logic [51:0]  f;
        logic         s;
        m   = a[66:64];
        err = (a[66:64] != b[66:64]) || (m > 3'd5);
        if (err) return '0;
        case (m)
            3'd0: k = 52;
            3'd1: k = 42;
            3'd2: k = 32;
            3'd3: k = 23;
            3'd4: k = 16;
            default: k = 10;
        endcase
        mask = {52{1'b1}} << (52 - k);
        s = a[63] ^ b[63];
        if (a[62:52] == 0 || b[62:52] == 0) return {m, s, 63'b0};
        sa = {1'b1, a[51:0] & mask};
        sb = {1'b1, b[51:0] & mask};
        p  = {53'b0, sa} * {53'b0, sb};
        e  = int'(a[62:52]) + int'(b[62:52]) - 1023 + int'(p[105]);
        f  = (p[105] ? p[104:53] : p[103:52]) & mask;
        if (e >= 2047) return {m, s, 11'h7FF, 52'b0};
        if (e <= 0)    return {m, s, 63'b0};
        return {m, s, e[10:0], f};
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic send(input logic [66:0] a, input logic [66:0] b, input string tag);
        exp_t x;
        bit   e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        in_valid = 1'b1;
        x.w   = ref_word(a, b, e);
        x.e   = e;
        x.v   = !e;
        x.due = cyc + 4;
        x.tag = tag;
        sbq.push_back(x);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // Monitor: each expected item is compared at the falling edge of its due cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                exp_t x;
                x = sbq.pop_front();
                n_cmp++;
                if (out_valid !== x.v || out_err !== x.e || out_word !== x.w) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b e=%0b w=%h, expected v=%0b e=%0b w=%h",
                             x.tag, out_valid, out_err, out_word, x.v, x.e, x.w);
                end
            end else if (out_valid || out_err) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10: unexpected output v=%0b e=%0b, expected none", out_valid, out_err);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R10: watchdog expired, got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        op_a = '0;
        op_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_word !== '0) begin
            n_bad++;
            $display("FAIL R11: got v=%0b e=%0b w=%h, expected all zero", out_valid, out_err, out_word);
        end
        rst = 1'b0;

        // R1 R4 R5 R6: 1.5*1.5 overflows into the top bit; 1.25*1.25 does not
        send(mk(0, 0, 1023, 52'h8000000000000), mk(0, 0, 1023, 52'h8000000000000), "R5");
        send(mk(0, 0, 1023, 52'h4000000000000), mk(0, 0, 1023, 52'h4000000000000), "R6");
        send(mk(3, 1, 1030, 52'h123456789ABCD), mk(3, 0, 1000, 52'hFEDCBA9876543), "R4");
        send(mk(1, 1, 900, 52'h0F0F0F0F0F0F0), mk(1, 1, 1100, 52'h3333333333333), "R1");
        // R2: every precision with dense fractions, issued back to back
        for (int m = 0; m < 6; m++) begin
            send(mk(m, 0, 1023, 52'hFFFFFFFFFFFFF), mk(m, 0, 1024, 52'hFFFFFFFFFFFFF), "R2");
            send(mk(m, 1, 1010, 52'hA5A5A5A5A5A5A), mk(m, 0, 1040, 52'h5A5A5A5A5A5A5), "R2");
        end
        // R3: mismatch and unassigned codes
        send(mk(1, 0, 1023, 52'h1), mk(2, 0, 1023, 52'h1), "R3");
        send(mk(6, 0, 1023, 52'h1), mk(6, 0, 1023, 52'h1), "R3");
        send(mk(7, 1, 1023, 52'h1), mk(7, 1, 1023, 52'h1), "R3");
        send(mk(0, 0, 1023, 52'h1), mk(5, 0, 1023, 52'h1), "R3");
        // R7: zero operand
        send(mk(0, 1, 0, 52'h0), mk(0, 0, 1200, 52'h8000000000000), "R7");
        send(mk(2, 0, 1100, 52'h1234500000000), mk(2, 1, 0, 52'h0), "R7");
        // R8: exponent overflow
        send(mk(0, 0, 2000, 52'h1), mk(0, 1, 2000, 52'h1), "R8");
        send(mk(4, 0, 1535, 52'h8000000000000), mk(4, 0, 1535, 52'h8000000000000), "R8");
        // R9: underflow and its boundary
        send(mk(0, 1, 100, 52'h1), mk(0, 0, 100, 52'h1), "R9");
        send(mk(0, 0, 512, 52'h0), mk(0, 0, 511, 52'h0), "R9");
        send(mk(0, 0, 512, 52'h0), mk(0, 0, 512, 52'h0), "R9");
        drain();

        // R10: random stream with gaps, mixed precisions and occasional mismatch
        for (int i = 0; i < 80; i++) begin
            logic [66:0] a, b;
            int m;
            rs = next_rand(rs);
            m = int'(rs[2:0] % 3'd6);
            a = mk(m, rs[3], 700 + int'(rs[13:4] % 10'd600), rs[63:12]);
            rs = next_rand(rs);
            b = mk(m, rs[3], 700 + int'(rs[13:4] % 10'd600), rs[63:12]);
            if (rs[7:4] == 4'hF) b[66:64] = 3'(m + 1);
            send(a, b, "R10");
            if (rs[1:0] == 2'b00) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        drain();

        // R10: idle cycles with changing operand data produce nothing
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rs = next_rand(rs);
            in_valid = 1'b0;
            op_a = {3'd0, rs};
            op_b = {3'd0, ~rs};
            n_cmp++;
            if (out_valid !== 1'b0 || out_err !== 1'b0) begin
                n_bad++;
                $display("FAIL R10: idle got v=%0b e=%0b, expected 0 0", out_valid, out_err);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule